// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a directory and a page table that sit in memory, and it reaches them through a word-wide memory port with a request/acknowledge handshake. A translation request carries the linear address, a write flag and a user-mode flag. The directory base, the paging enable and the large-page enable are sampled when the request is accepted. Only one translation is in flight at a time. It ends with a one-cycle done pulse that carries either the physical address or a page-fault flag. On a fault, the linear address is also held in a fault-address register.

At each level visited, the walker checks the entry's present, write-permission and user-permission bits. It then sets the accessed bit, and the dirty bit of the final entry on a write, through a write-back to the same word. When the large-page enable is set and the directory entry has its page-size bit set, the walk ends at the directory with a 4 MB mapping.

Entry bit layout: present = bit 0, writable = bit 1, user-allowed = bit 2, accessed = bit 5, dirty = bit 6, page-size = bit 7. Bits 31:12 hold the frame or table base.

Top module: `pt_walker`

## Requirements
- R1: With paging disabled at acceptance, the done pulse follows on the next cycle with the physical address equal to the linear address, no fault, and no memory access.
- R2: The directory entry is read at the word address {base[31:12], linear[31:22], 2'b00}. The low 12 bits of the base register are ignored. For a 4 KB walk the page-table entry is read at {directory entry[31:12], linear[21:12], 2'b00}.
- R3: A 4 KB walk with no fault returns {page-table entry[31:12], linear[11:0]}.
- R4: If a visited entry has bit 0 clear, the walk ends with a fault and fault_addr_o equals the linear address. That entry is not written and no further entry is read.
- R5: A write request faults at any visited entry whose bit 1 is clear. A read request ignores bit 1.
- R6: A user-mode request faults at any visited entry whose bit 2 is clear. A supervisor request ignores bit 2.
- R7: Every entry that passes its checks gets bit 5 set. The final entry of a write request also gets bit 6 set. All other bits of the entry keep their values, and neither flag is ever cleared.
- R8: A write-back happens only when it changes the entry, so a walk whose flags are already set writes nothing.
- R9: With the large-page enable set and directory bit 7 set, the walk reads only the directory entry and returns {directory entry[31:22], linear[21:0]}. The directory entry is then treated as the final entry for the dirty bit. With the enable clear, bit 7 is ignored.
- R10: req_ready_o is high only when no walk is in progress, so requests presented during a walk are not taken. done is a single-cycle pulse. While a memory request waits for its acknowledge, it holds its address and direction steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request may be taken |
| req_vaddr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Request is a write |
| req_user_i | input | 1 | Request comes from user mode |
| pdbr_i | input | 32 | Directory base register |
| paging_en_i | input | 1 | Paging enable |
| large_en_i | input | 1 | Large-page enable |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory access complete |
| resp_done_o | output | 1 | Translation finished (one cycle) |
| resp_fault_o | output | 1 | Translation faulted |
| resp_paddr_o | output | 32 | Physical address |
| fault_addr_o | output | 32 | Linear address of the last fault |

## Verification
A wrong state transition shows up at the memory port. The check is made at once on the read and write counts of the same walk: a missing or extra write-back, or a table read after a large-page hit or after a fault. A wrong latched entry or a wrong flag merge shows up when the table words are read back right after the done pulse. A corrupted frame field shows up in the physical address of that same pulse. The sweep covers every combination of present, writable, user, accessed, dirty and page-size bits together with the request's mode and direction, so a fault-priority mistake shows up within one walk of the first pattern that exposes it.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned LOFF_W  = OFF_W + IDX_W;
  localparam int unsigned FRAME_W = AW - OFF_W;
  localparam int unsigned BYTE_W  = OFF_W - IDX_W;

  localparam int unsigned BIT_P  = 0;
  localparam int unsigned BIT_RW = 1;
  localparam int unsigned BIT_US = 2;
  localparam int unsigned BIT_A  = 5;
  localparam int unsigned BIT_D  = 6;
  localparam int unsigned BIT_PS = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_DIR_WB, ST_TBL_RD, ST_TBL_WB
  } walk_st_e;

  function automatic logic [AW-1:0] leaf_paddr(logic [AW-1:0] ent, logic [AW-1:0] va,
                                               logic big);
    return big ? {ent[AW-1:LOFF_W], va[LOFF_W-1:0]} : {ent[AW-1:OFF_W], va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/pt_walker_perm.sv
module pt_walker_perm
  import pt_walker_pkg::*;
(
  input  logic [AW-1:0] entry_i,
  input  logic          write_i,
  input  logic          user_i,
  input  logic          leaf_i,
  output logic          fault_o,
  output logic          wb_o,
  output logic [AW-1:0] wdata_o
);
  logic need_d;

  always_comb begin
    fault_o = !entry_i[BIT_P] || (write_i && !entry_i[BIT_RW]) || (user_i && !entry_i[BIT_US]);
    need_d  = leaf_i && write_i && !entry_i[BIT_D];
    wb_o    = !entry_i[BIT_A] || need_d;
    wdata_o = entry_i;
    wdata_o[BIT_A] = 1'b1;
    if (need_d) wdata_o[BIT_D] = 1'b1;
  end
endmodule

// File: rtl/pt_walker_addr.sv
module pt_walker_addr
  import pt_walker_pkg::*;
(
  input  walk_st_e           st_i,
  input  logic [AW-1:0]      va_i,
  input  logic [FRAME_W-1:0] pdbr_i,
  input  logic [FRAME_W-1:0] pde_frame_i,
  input  logic [AW-1:0]      wb_data_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [AW-1:0]      mem_wdata_o
);
  logic [AW-1:0] dir_addr, tbl_addr;

  assign dir_addr = {pdbr_i, va_i[AW-1 -: IDX_W], {BYTE_W{1'b0}}};
  assign tbl_addr = {pde_frame_i, va_i[LOFF_W-1:OFF_W], {BYTE_W{1'b0}}};

  always_comb begin
    mem_req_o   = st_i != ST_IDLE;
    mem_we_o    = (st_i == ST_DIR_WB) || (st_i == ST_TBL_WB);
    mem_addr_o  = ((st_i == ST_TBL_RD) || (st_i == ST_TBL_WB)) ? tbl_addr : dir_addr;
    mem_wdata_o = wb_data_i;
  end
endmodule

// File: rtl/pt_walker_ctl.sv
module pt_walker_ctl
  import pt_walker_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [AW-1:0]      req_vaddr_i,
  input  logic               req_write_i,
  input  logic               req_user_i,
  input  logic [FRAME_W-1:0] pdbr_frame_i,
  input  logic               paging_en_i,
  input  logic               large_en_i,
  input  logic               mem_ack_i,
  input  logic [AW-1:0]      mem_rdata_i,
  input  logic               chk_fault_i,
  input  logic               chk_wb_i,
  input  logic [AW-1:0]      chk_wdata_i,
  output walk_st_e           st_o,
  output logic               req_ready_o,
  output logic [AW-1:0]      va_o,
  output logic [FRAME_W-1:0] pdbr_o,
  output logic [FRAME_W-1:0] pde_frame_o,
  output logic               wr_o,
  output logic               usr_o,
  output logic               leaf_o,
  output logic [AW-1:0]      wb_data_o,
  output logic               done_o,
  output logic               fault_o,
  output logic [AW-1:0]      paddr_o,
  output logic [AW-1:0]      fault_addr_o
);
  walk_st_e           st_q;
  logic [AW-1:0]      va_q, pde_q, pte_q, wb_q, paddr_q, fault_addr_q;
  logic [FRAME_W-1:0] pdbr_q;
  logic               wr_q, usr_q, large_en_q, large_q, done_q, fault_q;

  assign leaf_o = (st_q == ST_DIR_RD) ? (large_en_q && mem_rdata_i[BIT_PS]) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      va_q <= '0; pde_q <= '0; pte_q <= '0; wb_q <= '0;
      paddr_q <= '0; fault_addr_q <= '0; pdbr_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0; large_en_q <= 1'b0; large_q <= 1'b0;
      done_q <= 1'b0; fault_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q       <= req_vaddr_i;
          wr_q       <= req_write_i;
          usr_q      <= req_user_i;
          pdbr_q     <= pdbr_frame_i;
          large_en_q <= large_en_i;
          if (!paging_en_i) begin
            done_q  <= 1'b1;
            fault_q <= 1'b0;
            paddr_q <= req_vaddr_i;
          end else begin
            st_q <= ST_DIR_RD;
          end
        end
        ST_DIR_RD: if (mem_ack_i) begin
          pde_q   <= mem_rdata_i;
          wb_q    <= chk_wdata_i;
          large_q <= leaf_o;
          if (chk_fault_i) begin
            st_q <= ST_IDLE; done_q <= 1'b1; fault_q <= 1'b1; fault_addr_q <= va_q;
          end else if (chk_wb_i) begin
            st_q <= ST_DIR_WB;
          end else if (leaf_o) begin
            st_q <= ST_IDLE; done_q <= 1'b1; fault_q <= 1'b0;
            paddr_q <= leaf_paddr(mem_rdata_i, va_q, 1'b1);
          end else begin
            st_q <= ST_TBL_RD;
          end
        end
        ST_DIR_WB: if (mem_ack_i) begin
          if (large_q) begin
            st_q <= ST_IDLE; done_q <= 1'b1; fault_q <= 1'b0;
            paddr_q <= leaf_paddr(pde_q, va_q, 1'b1);
          end else begin
            st_q <= ST_TBL_RD;
          end
        end
        ST_TBL_RD: if (mem_ack_i) begin
          pte_q <= mem_rdata_i;
          wb_q  <= chk_wdata_i;
          if (chk_fault_i) begin
            st_q <= ST_IDLE; done_q <= 1'b1; fault_q <= 1'b1; fault_addr_q <= va_q;
          end else if (chk_wb_i) begin
            st_q <= ST_TBL_WB;
          end else begin
            st_q <= ST_IDLE; done_q <= 1'b1; fault_q <= 1'b0;
            paddr_q <= leaf_paddr(mem_rdata_i, va_q, 1'b0);
          end
        end
        ST_TBL_WB: if (mem_ack_i) begin
          st_q <= ST_IDLE; done_q <= 1'b1; fault_q <= 1'b0;
          paddr_q <= leaf_paddr(pte_q, va_q, 1'b0);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o         = st_q;
  assign req_ready_o  = st_q == ST_IDLE;
  assign va_o         = va_q;
  assign pdbr_o       = pdbr_q;
  assign pde_frame_o  = pde_q[AW-1:OFF_W];
  assign wr_o         = wr_q;
  assign usr_o        = usr_q;
  assign wb_data_o    = wb_q;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign paddr_o      = paddr_q;
  assign fault_addr_o = fault_addr_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_vaddr_i,
  input  logic          req_write_i,
  input  logic          req_user_i,
  input  logic [AW-1:0] pdbr_i,
  input  logic          paging_en_i,
  input  logic          large_en_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic [AW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          resp_done_o,
  output logic          resp_fault_o,
  output logic [AW-1:0] resp_paddr_o,
  output logic [AW-1:0] fault_addr_o
);
  walk_st_e           st;
  logic [AW-1:0]      va, wb_data, chk_wdata;
  logic [FRAME_W-1:0] pdbr_frame, pde_frame;
  logic               wr, usr, leaf, chk_fault, chk_wb;

  pt_walker_ctl u_ctl (
    .clk_i, .rst_ni, .req_valid_i, .req_vaddr_i, .req_write_i, .req_user_i,
    .pdbr_frame_i (pdbr_i[AW-1:OFF_W]),
    .paging_en_i, .large_en_i, .mem_ack_i, .mem_rdata_i,
    .chk_fault_i  (chk_fault),
    .chk_wb_i     (chk_wb),
    .chk_wdata_i  (chk_wdata),
    .st_o         (st),
    .req_ready_o,
    .va_o         (va),
    .pdbr_o       (pdbr_frame),
    .pde_frame_o  (pde_frame),
    .wr_o         (wr),
    .usr_o        (usr),
    .leaf_o       (leaf),
    .wb_data_o    (wb_data),
    .done_o       (resp_done_o),
    .fault_o      (resp_fault_o),
    .paddr_o      (resp_paddr_o),
    .fault_addr_o
  );

  pt_walker_perm u_perm (
    .entry_i (mem_rdata_i),
    .write_i (wr),
    .user_i  (usr),
    .leaf_i  (leaf),
    .fault_o (chk_fault),
    .wb_o    (chk_wb),
    .wdata_o (chk_wdata)
  );

  pt_walker_addr u_addr (
    .st_i        (st),
    .va_i        (va),
    .pdbr_i      (pdbr_frame),
    .pde_frame_i (pde_frame),
    .wb_data_i   (wb_data),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o
  );
endmodule

// File: rtl/pt_walker_sva.sv
module pt_walker_sva
  import pt_walker_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [AW-1:0] req_vaddr_i,
  input logic          paging_en_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic          resp_done_o,
  input logic          resp_fault_o,
  input logic [AW-1:0] resp_paddr_o,
  input logic [AW-1:0] fault_addr_o
);
  logic [AW-1:0] va_rec;
  logic          pg_rec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_rec <= '0;
      pg_rec <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      va_rec <= req_vaddr_i;
      pg_rec <= paging_en_i;
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  assert_busy_not_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
  assert_done_when_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_done_o |-> req_ready_o && !mem_req_o);
  assert_wb_sets_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[BIT_P] && mem_wdata_o[BIT_A]);
  assert_fault_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_done_o && resp_fault_o |-> fault_addr_o == va_rec);
  assert_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_done_o && !pg_rec |-> !resp_fault_o && resp_paddr_o == va_rec);
  assert_offset_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_done_o && !resp_fault_o |-> resp_paddr_o[OFF_W-1:0] == va_rec[OFF_W-1:0]);
endmodule

bind pt_walker pt_walker_sva u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_vaddr_i  (req_vaddr_i),
  .paging_en_i  (paging_en_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ack_i    (mem_ack_i),
  .resp_done_o  (resp_done_o),
  .resp_fault_o (resp_fault_o),
  .resp_paddr_o (resp_paddr_o),
  .fault_addr_o (fault_addr_o)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0, pdbr = 32'hC000_1ABC;
  logic        paging_en = 1'b0, large_en = 1'b0;
  logic        mem_req, mem_we, ack_q;
  logic [31:0] mem_addr, mem_wdata, rdata_q;
  logic        done, fault;
  logic [31:0] paddr, fault_addr;

  logic [31:0] mem [4096];
  int          rd_cnt, wr_cnt;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write), .req_user_i(req_user),
    .pdbr_i(pdbr), .paging_en_i(paging_en), .large_en_i(large_en),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(rdata_q), .mem_ack_i(ack_q),
    .resp_done_o(done), .resp_fault_o(fault), .resp_paddr_o(paddr), .fault_addr_o(fault_addr)
  );

  // memory: acknowledge one cycle after a request is seen; address bits above 13 ignored
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      rdata_q <= '0;
    end else if (mem_req && !ack_q) begin
      ack_q <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt++;
      end else begin
        rdata_q <= mem[mem_addr[13:2]];
        rd_cnt++;
      end
    end else begin
      ack_q <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [31:0] got_paddr, got_faddr;
  logic        got_fault, ready_leak;

  // one translation; returns at the negedge after the done pulse
  task automatic walk(input logic [31:0] va, input bit w, input bit u, input bit pg,
                      input bit lg, input logic [31:0] hold_va);
    int k;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_vaddr = va; req_write = w; req_user = u; paging_en = pg; large_en = lg;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ready_leak = 1'b0;
    k = 0;
    while (!done && k < 100) begin
      if (req_ready) ready_leak = 1'b1;
      if (k == 0) begin
        req_vaddr = hold_va;
        req_valid = (hold_va != va);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    got_fault = fault; got_paddr = paddr; got_faddr = fault_addr;
    chk(done, "R10", "done seen", {31'd0, done}, 32'd1);
    chk(!ready_leak, "R10", "ready low while busy", {31'd0, ready_leak}, 32'd0);
    @(negedge clk);
    chk(!done, "R10", "done single cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < 4096; j++) mem[j] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R10", "reset ready", {31'd0, req_ready}, 32'd1);
    chk(done === 1'b0, "R10", "reset done", {31'd0, done}, 32'd0);
    chk(mem_req === 1'b0, "R10", "reset mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;

    // R1: paging disabled passes the address through
    for (int j = 0; j < 8; j++) begin
      logic [31:0] va;
      va = 32'h1357_9BDF * (j + 1) ^ (32'hF0F0_0000 >> j);
      walk(va, j[0], j[1], 1'b0, j[2], va);
      chk(!got_fault, "R1", "bypass fault", {31'd0, got_fault}, 32'd0);
      chk(got_paddr == va, "R1", "bypass paddr", got_paddr, va);
      chk(rd_cnt + wr_cnt == 0, "R1", "bypass mem access", rd_cnt + wr_cnt, 0);
    end

    // sweep over entry flag combinations, request mode and direction
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] pde, pte, va, e_pde, e_pte, e_pa;
      logic [9:0]  d, t;
      logic [11:0] off;
      bit w, u, len, lg, e_fault;
      int e_rd, e_wr;
      string tag;
      d = 10'((i * 37) % 1024);
      t = 10'((i * 53 + 7) % 1024);
      off = 12'((i * 97) % 4096);
      va = {d, t, off};
      w = i[10]; u = i[11];
      len = i[3] ^ i[7] ^ i[10];
      pde = {10'(i ^ 'h2A5), 8'(i * 3), 2'b10, 12'h200};
      pde[0] = i[0]; pde[1] = i[1]; pde[2] = i[2]; pde[5] = i[3]; pde[7] = i[4]; pde[6] = i[9];
      pte = {20'hF0000 ^ 20'(i * 7), 12'h300};
      pte[0] = i[5]; pte[1] = i[6]; pte[2] = i[7]; pte[5] = i[8]; pte[6] = i[9];
      mem[1024 + int'(d)] = pde;
      mem[2048 + int'(t)] = pte;
      lg = len && pde[7];
      e_pde = pde; e_pte = pte; e_rd = 1; e_wr = 0; e_fault = 1'b0; e_pa = '0;
      if (!pde[0] || (w && !pde[1]) || (u && !pde[2])) begin
        e_fault = 1'b1;
        tag = !pde[0] ? "R4" : (w && !pde[1]) ? "R5" : "R6";
      end else begin
        e_pde = pde | 32'h20 | ((lg && w) ? 32'h40 : 32'h0);
        if (e_pde != pde) e_wr++;
        if (lg) begin
          e_pa = {pde[31:22], va[21:0]};
          tag = "R9";
        end else begin
          e_rd = 2;
          if (!pte[0] || (w && !pte[1]) || (u && !pte[2])) begin
            e_fault = 1'b1;
            tag = !pte[0] ? "R4" : (w && !pte[1]) ? "R5" : "R6";
          end else begin
            e_pte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
            if (e_pte != pte) e_wr++;
            e_pa = {pte[31:12], va[11:0]};
            tag = "R3";
          end
        end
      end
      walk(va, w, u, 1'b1, len, (i % 64 == 0) ? ~va : va);
      chk(got_fault == e_fault, tag, "fault flag", {31'd0, got_fault}, {31'd0, e_fault});
      if (e_fault) chk(got_faddr == va, "R4", "fault address", got_faddr, va);
      else chk(got_paddr == e_pa, tag, "physical address", got_paddr, e_pa);
      chk(rd_cnt == e_rd, "R2", "entry reads", rd_cnt, e_rd);
      chk(wr_cnt == e_wr, "R8", "write-backs", wr_cnt, e_wr);
      chk(mem[1024 + int'(d)] == e_pde, "R7", "directory entry", mem[1024 + int'(d)], e_pde);
      chk(mem[2048 + int'(t)] == e_pte, "R7", "table entry", mem[2048 + int'(t)], e_pte);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule